// File: doc/BRIEF.md
# Flag-Producing Integer ALU and Comparator

This block is the integer execute stage of a small RISC core with sixteen general registers and one condition bit. Each clock it takes an operation select, the two register operands (the destination-side operand `rnVal` and the source-side operand `rmVal`) and an 8-bit immediate. It produces a registered result with a write-enable and updates its own condition bit T and the two divide-step bits M and Q.

The operations are plain and immediate addition, carry-chained and overflow-checked addition, signed and unsigned magnitude compares, equality and sign tests, a byte-lane match test for string scanning, decrement-and-test, the two divide-step initialisers, and byte and halfword sign and zero extension. Compares report through T alone. T is also the carry input and carry output of the chained add. Opcode decode, the register file and the divide iteration itself sit outside the block.

All outputs are registered. An operation presented before a rising edge shows its result, write-enable and flags after that edge. T, M and Q are state kept inside the block and exposed on ports.

Top module: `flag_alu`

## Requirements
- R1: While `rstN` is low and right after reset, `result`, `wrEn`, `tFlag`, `mFlag` and `qFlag` are all 0.
- R2: Op 1 writes `rnVal + rmVal`. Op 2 writes `rnVal` plus the 8-bit immediate sign-extended to 32 bits. Both raise `wrEn`, wrap modulo 2^32 and leave T unchanged.
- R3: Op 3 writes `rnVal + rmVal + T` and sets T to the carry out of that 33-bit sum.
- R4: Op 4 writes the wrapped sum `rnVal + rmVal` and sets T to bit 31 of `~(rnVal ^ rmVal) & (sum ^ rnVal)`, which is signed overflow.
- R5: Op 5 sets T when `rnVal == rmVal`. Op 6 sets T when `rnVal` equals the sign-extended immediate. Op 7 sets T on signed `rnVal >= rmVal` and op 8 on signed `rnVal > rmVal`. Every compare (ops 5 to 13 and 15 to 16) keeps `wrEn` low and `result` at 0.
- R6: Op 9 sets T on unsigned `rnVal > rmVal` and op 10 on unsigned `rnVal >= rmVal`.
- R7: Op 11 sets T when `rnVal` is signed and strictly positive. Op 12 sets T when `rnVal` is signed and not negative.
- R8: Op 13 sets T when at least one of the four byte lanes of `rnVal ^ rmVal` is zero.
- R9: Op 14 writes `rnVal - 1` and sets T exactly when that new value is zero.
- R10: Op 15 clears M, Q and T. Op 16 sets Q to `rnVal[31]`, M to `rmVal[31]` and T to M xor Q. No other op changes M or Q.
- R11: Op 17 writes `rmVal[7:0]` sign-extended and op 18 writes `rmVal[15:0]` sign-extended. Op 19 writes `rmVal & 0xFF` and op 20 writes `rmVal & 0xFFFF`. All four raise `wrEn` and leave T unchanged.
- R12: Code 0 and the unlisted codes 21 to 31 give `result` 0 and `wrEn` low, and leave T, M and Q unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opSel | input | 5 | Operation code (see requirements) |
| rnVal | input | 32 | Destination-side register operand |
| rmVal | input | 32 | Source-side register operand |
| immVal | input | 8 | Immediate, sign-extended where used |
| result | output | 32 | Registered result, 0 when no write |
| wrEn | output | 1 | Registered register write-enable |
| tFlag | output | 1 | Condition bit T |
| mFlag | output | 1 | Divide-step bit M |
| qFlag | output | 1 | Divide-step bit Q |

## Verification
The assertions assume that `opSel`, `rnVal`, `rmVal` and `immVal` are stable across each rising edge, so that the `$past` operand values match what the edge captured. They also assume the operands carry no X or Z. The stimulus changes every input only on the falling edge and drives only defined values, drawn from a fixed set of sign and carry corner values plus a full sweep of the immediate. Before each swept operation the bench forces T to a known value with an equality compare, so the flag-holding checks see both T states.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [4:0] {
    OP_NOP    = 5'd0,
    OP_ADD    = 5'd1,
    OP_ADDI   = 5'd2,
    OP_ADDC   = 5'd3,
    OP_ADDV   = 5'd4,
    OP_CMPEQ  = 5'd5,
    OP_CMPEQI = 5'd6,
    OP_CMPGE  = 5'd7,
    OP_CMPGT  = 5'd8,
    OP_CMPHI  = 5'd9,
    OP_CMPHS  = 5'd10,
    OP_CMPPL  = 5'd11,
    OP_CMPPZ  = 5'd12,
    OP_CMPSTR = 5'd13,
    OP_DT     = 5'd14,
    OP_DIV0U  = 5'd15,
    OP_DIV0S  = 5'd16,
    OP_EXTSB  = 5'd17,
    OP_EXTSW  = 5'd18,
    OP_EXTUB  = 5'd19,
    OP_EXTUW  = 5'd20
  } aluOp_e;

  typedef enum logic [2:0] {
    RES_ZERO, RES_SUM, RES_DEC, RES_EXTSB, RES_EXTSW, RES_EXTUB, RES_EXTUW
  } resSel_e;

  typedef enum logic [3:0] {
    TS_HOLD, TS_CARRY, TS_OVF, TS_EQ, TS_GE, TS_GT, TS_HI, TS_HS,
    TS_PL, TS_PZ, TS_STR, TS_DECZ, TS_DIV
  } tSel_e;

  typedef enum logic [1:0] {
    MQ_HOLD, MQ_CLEAR, MQ_SIGNED
  } mqSel_e;

  typedef struct packed {
    logic    wr;
    logic    useImm;
    logic    useCarry;
    resSel_e resSel;
    tSel_e   tSel;
    mqSel_e  mqSel;
  } strobe_t;

endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic [4:0] opSel,
  output strobe_t    strobe
);

  aluOp_e opCode;
  assign opCode = aluOp_e'(opSel);

  always_comb begin
    strobe = '{wr: 1'b0, useImm: 1'b0, useCarry: 1'b0,
               resSel: RES_ZERO, tSel: TS_HOLD, mqSel: MQ_HOLD};
    case (opCode)
      OP_ADD:    begin strobe.wr = 1'b1; strobe.resSel = RES_SUM; end
      OP_ADDI:   begin strobe.wr = 1'b1; strobe.resSel = RES_SUM; strobe.useImm = 1'b1; end
      OP_ADDC:   begin strobe.wr = 1'b1; strobe.resSel = RES_SUM; strobe.useCarry = 1'b1;
                       strobe.tSel = TS_CARRY; end
      OP_ADDV:   begin strobe.wr = 1'b1; strobe.resSel = RES_SUM; strobe.tSel = TS_OVF; end
      OP_CMPEQ:  strobe.tSel = TS_EQ;
      OP_CMPEQI: begin strobe.tSel = TS_EQ; strobe.useImm = 1'b1; end
      OP_CMPGE:  strobe.tSel = TS_GE;
      OP_CMPGT:  strobe.tSel = TS_GT;
      OP_CMPHI:  strobe.tSel = TS_HI;
      OP_CMPHS:  strobe.tSel = TS_HS;
      OP_CMPPL:  strobe.tSel = TS_PL;
      OP_CMPPZ:  strobe.tSel = TS_PZ;
      OP_CMPSTR: strobe.tSel = TS_STR;
      OP_DT:     begin strobe.wr = 1'b1; strobe.resSel = RES_DEC; strobe.tSel = TS_DECZ; end
      OP_DIV0U:  begin strobe.tSel = TS_DIV; strobe.mqSel = MQ_CLEAR; end
      OP_DIV0S:  begin strobe.tSel = TS_DIV; strobe.mqSel = MQ_SIGNED; end
      OP_EXTSB:  begin strobe.wr = 1'b1; strobe.resSel = RES_EXTSB; end
      OP_EXTSW:  begin strobe.wr = 1'b1; strobe.resSel = RES_EXTSW; end
      OP_EXTUB:  begin strobe.wr = 1'b1; strobe.resSel = RES_EXTUB; end
      OP_EXTUW:  begin strobe.wr = 1'b1; strobe.resSel = RES_EXTUW; end
      default:   ;
    endcase
  end

endmodule

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] rnVal,
  input  logic [DATA_W-1:0] rmVal,
  input  logic [IMM_W-1:0]  immVal,
  input  logic              tCur,
  input  logic              mCur,
  input  logic              qCur,
  output logic [DATA_W-1:0] resNext,
  output logic              tNext,
  output logic              mNext,
  output logic              qNext
);

  localparam int LANES = DATA_W / 8;
  localparam int HALF  = 16;

  logic [DATA_W-1:0] immExt, opB, sumVal, decVal, xorVal;
  logic [DATA_W:0]   sumFull;
  logic [LANES-1:0]  laneZero;
  logic              ovfBit, mSigned, qSigned;

  assign immExt = {{(DATA_W-IMM_W){immVal[IMM_W-1]}}, immVal};
  assign opB    = strobe.useImm ? immExt : rmVal;

  // one adder serves plain, immediate and carry-chained addition
  assign sumFull = {1'b0, rnVal} + {1'b0, opB} + (DATA_W+1)'(strobe.useCarry & tCur);
  assign sumVal  = sumFull[DATA_W-1:0];
  assign ovfBit  = (~(rnVal[DATA_W-1] ^ opB[DATA_W-1])) & (sumVal[DATA_W-1] ^ rnVal[DATA_W-1]);
  assign decVal  = rnVal - DATA_W'(1);
  assign xorVal  = rnVal ^ rmVal;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign laneZero[ln] = (xorVal[ln*8 +: 8] == 8'd0);
  end

  always_comb begin
    case (strobe.resSel)
      RES_SUM:   resNext = sumVal;
      RES_DEC:   resNext = decVal;
      RES_EXTSB: resNext = {{(DATA_W-8){rmVal[7]}}, rmVal[7:0]};
      RES_EXTSW: resNext = {{(DATA_W-HALF){rmVal[HALF-1]}}, rmVal[HALF-1:0]};
      RES_EXTUB: resNext = {{(DATA_W-8){1'b0}}, rmVal[7:0]};
      RES_EXTUW: resNext = {{(DATA_W-HALF){1'b0}}, rmVal[HALF-1:0]};
      default:   resNext = '0;
    endcase
  end

  assign qSigned = rnVal[DATA_W-1];
  assign mSigned = rmVal[DATA_W-1];

  always_comb begin
    case (strobe.mqSel)
      MQ_CLEAR:  begin mNext = 1'b0;    qNext = 1'b0;    end
      MQ_SIGNED: begin mNext = mSigned; qNext = qSigned; end
      default:   begin mNext = mCur;    qNext = qCur;    end
    endcase
  end

  always_comb begin
    case (strobe.tSel)
      TS_CARRY: tNext = sumFull[DATA_W];
      TS_OVF:   tNext = ovfBit;
      TS_EQ:    tNext = (rnVal == opB);
      TS_GE:    tNext = ($signed(rnVal) >= $signed(rmVal));
      TS_GT:    tNext = ($signed(rnVal) >  $signed(rmVal));
      TS_HI:    tNext = (rnVal >  rmVal);
      TS_HS:    tNext = (rnVal >= rmVal);
      TS_PL:    tNext = ($signed(rnVal) > $signed(DATA_W'(0)));
      TS_PZ:    tNext = ~rnVal[DATA_W-1];
      TS_STR:   tNext = |laneZero;
      TS_DECZ:  tNext = (decVal == '0);
      TS_DIV:   tNext = mNext ^ qNext;
      default:  tNext = tCur;
    endcase
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        opSel,
  input  logic [DATA_W-1:0] rnVal,
  input  logic [DATA_W-1:0] rmVal,
  input  logic [IMM_W-1:0]  immVal,
  output logic [DATA_W-1:0] result,
  output logic              wrEn,
  output logic              tFlag,
  output logic              mFlag,
  output logic              qFlag
);

  strobe_t           strobe;
  logic [DATA_W-1:0] resNext;
  logic              tNext, mNext, qNext;

  flag_alu_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  flag_alu_dp #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .strobe  (strobe),
    .rnVal   (rnVal),
    .rmVal   (rmVal),
    .immVal  (immVal),
    .tCur    (tFlag),
    .mCur    (mFlag),
    .qCur    (qFlag),
    .resNext (resNext),
    .tNext   (tNext),
    .mNext   (mNext),
    .qNext   (qNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      wrEn   <= 1'b0;
      tFlag  <= 1'b0;
      mFlag  <= 1'b0;
      qFlag  <= 1'b0;
    end else begin
      result <= strobe.wr ? resNext : '0;
      wrEn   <= strobe.wr;
      tFlag  <= tNext;
      mFlag  <= mNext;
      qFlag  <= qNext;
    end
  end

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
  import flag_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [4:0]        opSel,
  input logic [DATA_W-1:0] rnVal,
  input logic [DATA_W-1:0] rmVal,
  input logic [IMM_W-1:0]  immVal,
  input logic [DATA_W-1:0] result,
  input logic              wrEn,
  input logic              tFlag,
  input logic              mFlag,
  input logic              qFlag
);

  logic isCompare, isExtend, isIdle;
  assign isCompare = (opSel >= 5'd5 && opSel <= 5'd13) || opSel == 5'd15 || opSel == 5'd16;
  assign isExtend  = (opSel >= 5'd17 && opSel <= 5'd20);
  assign isIdle    = (opSel == 5'd0) || (opSel >= 5'd21);

  AST_ADD_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    opSel == OP_ADD |=> wrEn && result == $past(rnVal + rmVal)); // R2

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    isCompare |=> !wrEn && result == '0); // R5

  AST_DT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_DT && rnVal == DATA_W'(1)) |=> tFlag && wrEn && result == '0); // R9

  AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    opSel == OP_DIV0U |=> !tFlag && !mFlag && !qFlag); // R10

  AST_EXT_T_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    isExtend |=> $stable(tFlag) && wrEn); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    isIdle |=> !wrEn && $stable(tFlag) && $stable(mFlag) && $stable(qFlag)); // R12

  AST_SEXT_IMM: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == OP_ADDI && immVal[IMM_W-1]) |=>
      result == $past(rnVal) - DATA_W'((1 << IMM_W) - $past(immVal))); // R2

endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .opSel  (opSel),
  .rnVal  (rnVal),
  .rmVal  (rmVal),
  .immVal (immVal),
  .result (result),
  .wrEn   (wrEn),
  .tFlag  (tFlag),
  .mFlag  (mFlag),
  .qFlag  (qFlag)
);

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  opSel = '0;
  logic [31:0] rnVal = '0;
  logic [31:0] rmVal = '0;
  logic [7:0]  immVal = '0;
  logic [31:0] result;
  logic        wrEn, tFlag, mFlag, qFlag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic mdlT = 1'b0, mdlM = 1'b0, mdlQ = 1'b0;

  always #10 clk = ~clk;

  flag_alu u_dut (
    .clk(clk), .rstN(rstN), .opSel(opSel), .rnVal(rnVal), .rmVal(rmVal),
    .immVal(immVal), .result(result), .wrEn(wrEn), .tFlag(tFlag),
    .mFlag(mFlag), .qFlag(qFlag)
  );

  function automatic string tagOf(input int op);
    case (op)
      1, 2:             return "R2";
      3:                return "R3";
      4:                return "R4";
      5, 6, 7, 8:       return "R5";
      9, 10:            return "R6";
      11, 12:           return "R7";
      13:               return "R8";
      14:               return "R9";
      15, 16:           return "R10";
      17, 18, 19, 20:   return "R11";
      default:          return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // expected behaviour derived from the requirement text
  task automatic predict(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic [7:0] imm, output logic [31:0] r, output logic w);
    logic [31:0] k;
    logic [32:0] s;
    k = {{24{imm[7]}}, imm};
    r = 32'd0;
    w = 1'b0;
    case (op)
      1: begin r = a + b; w = 1'b1; end
      2: begin r = a + k; w = 1'b1; end
      3: begin s = 33'(a) + 33'(b) + 33'(mdlT); r = s[31:0]; w = 1'b1; mdlT = s[32]; end
      4: begin r = a + b; w = 1'b1;
               mdlT = (a[31] == b[31]) && (r[31] != a[31]); end
      5:  mdlT = (a == b);
      6:  mdlT = (a == k);
      7:  mdlT = ($signed(a) >= $signed(b));
      8:  mdlT = ($signed(a) > $signed(b));
      9:  mdlT = (a > b);
      10: mdlT = (a >= b);
      11: mdlT = !a[31] && (a != 0);
      12: mdlT = !a[31];
      13: begin k = a ^ b;
                mdlT = (k[7:0] == 0) || (k[15:8] == 0) || (k[23:16] == 0) || (k[31:24] == 0); end
      14: begin r = a - 32'd1; w = 1'b1; mdlT = (r == 0); end
      15: begin mdlM = 1'b0; mdlQ = 1'b0; mdlT = 1'b0; end
      16: begin mdlQ = a[31]; mdlM = b[31]; mdlT = mdlM ^ mdlQ; end
      17: begin r = {{24{b[7]}}, b[7:0]};   w = 1'b1; end
      18: begin r = {{16{b[15]}}, b[15:0]}; w = 1'b1; end
      19: begin r = b & 32'hFF;   w = 1'b1; end
      20: begin r = b & 32'hFFFF; w = 1'b1; end
      default: ;
    endcase
  endtask

  task automatic runOp(input int op, input logic [31:0] a, input logic [31:0] b,
                       input logic [7:0] imm);
    logic [31:0] er;
    logic        ew;
    string       tg;
    @(negedge clk);
    opSel = 5'(op); rnVal = a; rmVal = b; immVal = imm;
    predict(op, a, b, imm, er, ew);
    tg = tagOf(op);
    @(posedge clk);
    #2;
    chk(tg, "result", result, er);
    chk(tg, "wrEn", 32'(wrEn), 32'(ew));
    chk(tg, "T", 32'(tFlag), 32'(mdlT));
    chk(tg, "M", 32'(mFlag), 32'(mdlM));
    chk(tg, "Q", 32'(qFlag), 32'(mdlQ));
  endtask

  logic [31:0] corners [10] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF,
                                32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_00FF,
                                32'h0000_FF80, 32'h1234_5678, 32'h1299_5633,
                                32'hFFFF_7F00};

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1", "result", result, 32'd0);
    chk("R1", "flags", {29'd0, wrEn, tFlag, mFlag, qFlag}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // sweep every code over corner operand pairs, with T preset to both values
    for (int op = 0; op < 32; op++) begin
      for (int ia = 0; ia < 10; ia++) begin
        for (int ib = 0; ib < 10; ib++) begin
          for (int tv = 0; tv < 2; tv++) begin
            runOp(5, 32'd7, (tv == 1) ? 32'd7 : 32'd8, 8'd0); // sets T to tv
            runOp(op, corners[ia], corners[ib], corners[(ia + ib) % 10][7:0]);
          end
        end
      end
    end

    // R2 and R5: full immediate sweep for sign extension
    for (int iv = 0; iv < 256; iv++) begin
      runOp(2, 32'h0000_0100, 32'd0, 8'(iv));
      runOp(6, 32'hFFFF_FF80, 32'd0, 8'(iv));
    end

    // R3: carry chaining across a 64-bit add
    runOp(5, 32'd1, 32'd2, 8'd0);
    runOp(3, 32'hFFFF_FFFF, 32'h0000_0001, 8'd0);
    runOp(3, 32'h0000_0000, 32'h0000_0000, 8'd0);
    // R3: carry from the T stage alone
    runOp(5, 32'd1, 32'd1, 8'd0);
    runOp(3, 32'hFFFF_FFFF, 32'h0000_0000, 8'd0);

    // R9: decrement to zero and through zero
    runOp(14, 32'd1, 32'd0, 8'd0);
    runOp(14, 32'd0, 32'd0, 8'd0);

    // R10 then R12: M and Q held by a later idle code
    runOp(16, 32'h8000_0000, 32'h0000_0000, 8'd0);
    runOp(25, 32'h1, 32'h1, 8'd0);
    runOp(31, 32'h0, 32'h0, 8'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule